// File: doc/BRIEF.md
# Parallel Port FIFO Mode Controller

This block is the host-facing register and FIFO front end of a bidirectional IEEE 1284 parallel port. A host reaches it over a small register bus. The low bank lies at offsets 0x000 to 0x007. The high bank at 0x400 to 0x402 is reached only with address bit 10 set. A three-bit mode field in the extended control register at 0x402 decides what each offset means. In several modes the offsets open one shared FIFO of 16 entries. Each entry is nine bits wide, and its top bit marks a command byte.

In the forward direction, bytes leave the FIFO through a one-byte holding stage toward the cable-side engine, which takes them with a valid/ready pair. In the reverse direction, the cable-side engine pushes bytes in and the host reads them out. A service condition watches the fill level against a threshold. It drives an active-low interrupt pulse when the host services the FIFO by polling. It drives a DMA request with hysteresis when DMA does the transfers. In the plain printer modes, the interrupt line simply follows the acknowledge input.

Top module: `ppfifo_ctrl`

## Requirements
- R1: After reset the extended control register reads 0x01: mode field 000 in bits 7:5, option bits 4:2 zero, FIFO empty in bit 0, full clear in bit 1. tx_valid, rx_ready and dma_req are low, and irq_n follows ack_n_in.
- R2: Offset 0x402 is the extended control register. Offset 0x400 depends on the mode: 010 is a write-only data FIFO whose reads return 0x00, 011 is the data FIFO, 110 is a test FIFO that the host both writes and reads, and 111 reads the constant CFGA_VAL. In mode 111, offset 0x401 is a read/write configuration byte. A FIFO read while the FIFO is empty returns 0x00 and removes nothing.
- R3: In mode 011 with the forward direction, a write to 0x000 enters the FIFO tagged as a command (tx_cmd=1), and a write to 0x400 enters it untagged. In modes 000 and 001, a write to 0x000 loads the data latch, which drives pd_out and reads back at 0x000.
- R4: epp_addr_stb rises during an access to 0x003, and epp_data_stb during an access to 0x004 to 0x007, only while the mode is 100.
- R5: The FIFO holds 16 entries in arrival order. Bit 1 of the extended control register reads full and bit 0 reads empty. A push into a full FIFO is dropped.
- R6: The holding stage is not counted by the full flag, so 17 bytes can be pending in the forward direction. They leave in write order, one per cycle while tx_ready is high.
- R7: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold steady unless a flush occurs.
- R8: In modes 010 and 011, with bit 2 (service enable) set and bit 3 (DMA enable) clear, irq_n pulses low for exactly one cycle each time the service condition becomes true. The condition is at least 8 free slots in the forward direction, or at least 8 stored bytes in the reverse direction.
- R9: In modes 000 and 001, irq_n equals ack_n_in at every moment and is not pulsed.
- R10: With bit 3 set in modes 010 and 011, dma_req rises one cycle after the service condition holds. It then stays high until the FIFO is full (forward) or empty (reverse). dma_req is never high without DMA enabled in the previous cycle.
- R11: Writing the extended control register with a mode field of 000 or 001 empties both the FIFO and the holding stage.
- R12: In mode 011 with the reverse direction (control register at 0x002, bit 5 set), the cable side pushes with rx_valid while rx_ready (not full) is high. Host reads at 0x400 return the bytes in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hb_sel | input | 1 | Host access in this cycle |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 11 | Host register offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data (combinational) |
| pd_out | output | 8 | Data latch toward the cable |
| epp_addr_stb | output | 1 | EPP address-port access strobe |
| epp_data_stb | output | 1 | EPP data-port access strobe |
| tx_valid | output | 1 | Holding stage holds a byte |
| tx_data | output | 8 | Byte in the holding stage |
| tx_cmd | output | 1 | Holding-stage byte is a command |
| tx_ready | input | 1 | Cable side takes the byte |
| rx_valid | input | 1 | Cable side offers a reverse byte |
| rx_data | input | 8 | Reverse byte |
| rx_ready | output | 1 | Reverse byte can be accepted |
| ack_n_in | input | 1 | Acknowledge level from the cable |
| irq_n | output | 1 | Active-low interrupt |
| dma_req | output | 1 | DMA request |

## Verification
Several properties are checked on every cycle. The fill count never passes the depth. The EPP strobes never appear outside mode 100. An interrupt pulse never lasts two cycles, and one follows every enabled service edge. A request seen while the FIFO is full in the forward direction drops on the next cycle. A flush leaves FIFO and holding stage empty. A stalled holding byte stays steady. Only the bench's scenarios can show the rest: data order through the FIFO and the holding stage, the count of 17 pending bytes, the dropped push, the mode-dependent read values, the hysteresis span of dma_req in the reverse direction, and the level-following acknowledge interrupt.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  typedef enum logic [2:0] {
    MD_COMPAT = 3'd0,
    MD_BIDIR  = 3'd1,
    MD_PPFIFO = 3'd2,
    MD_ECP    = 3'd3,
    MD_EPP    = 3'd4,
    MD_RSVD   = 3'd5,
    MD_TEST   = 3'd6,
    MD_CFG    = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    RS_NONE, RS_LATCH, RS_CTRL, RS_FIFO, RS_CFGA, RS_CFGB, RS_ECR
  } rsel_e;

  // Service condition: forward wants free slots, reverse wants stored bytes.
  function automatic logic svc_hit(input int cnt, input int depth,
                                   input int thr, input logic rev);
    if (rev) return cnt >= thr;
    return (depth - cnt) >= thr;
  endfunction

  // Mode codes whose selection empties the queue.
  function automatic logic is_flush_mode(input mode_e m);
    return (m == MD_COMPAT) || (m == MD_BIDIR);
  endfunction

  function automatic logic is_queue_mode(input mode_e m);
    return (m == MD_PPFIFO) || (m == MD_ECP);
  endfunction

endpackage

// File: rtl/ppf_fifo.sv
module ppf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ppf_regdec.sv
module ppf_regdec
  import ppf_pkg::*;
(
  input  logic        sel,
  input  logic        wr,
  input  logic [10:0] addr,
  input  mode_e       mode,
  input  logic        rev,
  output logic        wr_latch,
  output logic        wr_ctrl,
  output logic        wr_ecr,
  output logic        wr_cfgb,
  output logic        push_data,
  output logic        push_cmd,
  output logic        pop_req,
  output logic        epp_a,
  output logic        epp_d,
  output rsel_e       rsel
);
  logic       lo, hi;
  logic [2:0] off;
  logic       host_fill, host_drain;

  assign off = addr[2:0];
  assign lo  = sel && (addr[10:3] == 8'd0);
  assign hi  = sel && addr[10] && (addr[9:2] == 8'd0) && (addr[1:0] != 2'd3);

  assign host_fill  = (is_queue_mode(mode) && !rev) || (mode == MD_TEST);
  assign host_drain = ((mode == MD_ECP) && rev) || (mode == MD_TEST);

  assign wr_latch  = wr && lo && (off == 3'd0) && is_flush_mode(mode);
  assign wr_ctrl   = wr && lo && (off == 3'd2);
  assign push_cmd  = wr && lo && (off == 3'd0) && (mode == MD_ECP) && !rev;
  assign wr_ecr    = wr && hi && (off == 3'd2);
  assign wr_cfgb   = wr && hi && (off == 3'd1) && (mode == MD_CFG);
  assign push_data = wr && hi && (off == 3'd0) && host_fill;
  assign pop_req   = !wr && hi && (off == 3'd0) && host_drain;
  assign epp_a     = lo && (off == 3'd3) && (mode == MD_EPP);
  assign epp_d     = lo && off[2] && (mode == MD_EPP);

  always_comb begin
    rsel = RS_NONE;
    if (lo) begin
      if (off == 3'd0)      rsel = RS_LATCH;
      else if (off == 3'd2) rsel = RS_CTRL;
    end else if (hi) begin
      case (addr[1:0])
        2'd0: begin
          if (host_drain)          rsel = RS_FIFO;
          else if (mode == MD_CFG) rsel = RS_CFGA;
        end
        2'd1: if (mode == MD_CFG) rsel = RS_CFGB;
        2'd2: rsel = RS_ECR;
        default: rsel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ppf_svc.sv
module ppf_svc
  import ppf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic          rev,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic          full,
  input  logic          sie,
  input  logic          dma_en,
  input  logic          ack_n,
  output logic          irq_n,
  output logic          dma_req,
  output logic          svc_rise
);
  logic active, svc_now, svc_q, pulse_q, dma_q, dma_next, stop;

  assign active   = is_queue_mode(mode);
  assign svc_now  = active && svc_hit(int'(count), DEPTH, THRESH, rev);
  assign svc_rise = svc_now && !svc_q;
  assign stop     = rev ? empty : full;

  always_comb begin
    dma_next = dma_q;
    if (!(active && dma_en)) dma_next = 1'b0;
    else if (stop)           dma_next = 1'b0;
    else if (svc_now)        dma_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q   <= 1'b0;
      pulse_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      svc_q   <= svc_now;
      pulse_q <= svc_rise && sie && !dma_en;
      dma_q   <= dma_next;
    end
  end

  assign dma_req = dma_q;

  always_comb begin
    if (is_flush_mode(mode)) irq_n = ack_n;
    else if (active)         irq_n = !pulse_q;
    else                     irq_n = 1'b1;
  end
endmodule

// File: rtl/ppfifo_ctrl.sv
module ppfifo_ctrl
  import ppf_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          THRESH   = 8,
  parameter logic [7:0]  CFGA_VAL = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_sel,
  input  logic        hb_wr,
  input  logic [10:0] hb_addr,
  input  logic [7:0]  hb_wdata,
  output logic [7:0]  hb_rdata,
  output logic [7:0]  pd_out,
  output logic        epp_addr_stb,
  output logic        epp_data_stb,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_cmd,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  input  logic        ack_n_in,
  output logic        irq_n,
  output logic        dma_req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 9;

  mode_e          mode_q;
  logic [4:2]     ecr_opt_q;
  logic [7:0]     ctrl_q, cfgb_q, pd_q;
  logic           rev, sie, dma_en;
  logic           wr_latch, wr_ctrl, wr_ecr, wr_cfgb;
  logic           push_data, push_cmd, pop_req;
  rsel_e          rsel;
  logic           flush, rx_push, draw, hold_take, hold_load;
  logic           fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [EW-1:0]  fifo_wdata, fifo_head, hold_q;
  logic           hold_v;
  logic [CW-1:0]  count;
  logic           svc_evt;

  assign rev    = ctrl_q[5];
  assign sie    = ecr_opt_q[2];
  assign dma_en = ecr_opt_q[3];

  ppf_regdec u_dec (
    .sel(hb_sel), .wr(hb_wr), .addr(hb_addr), .mode(mode_q), .rev(rev),
    .wr_latch(wr_latch), .wr_ctrl(wr_ctrl), .wr_ecr(wr_ecr), .wr_cfgb(wr_cfgb),
    .push_data(push_data), .push_cmd(push_cmd), .pop_req(pop_req),
    .epp_a(epp_addr_stb), .epp_d(epp_data_stb), .rsel(rsel)
  );

  assign flush      = wr_ecr && is_flush_mode(mode_e'(hb_wdata[7:5]));
  assign rx_push    = rx_valid && (mode_q == MD_ECP) && rev;
  assign draw       = is_queue_mode(mode_q) && !rev;
  assign hold_take  = hold_v && tx_ready;
  assign hold_load  = draw && !fifo_empty && (!hold_v || hold_take);
  assign fifo_push  = push_data || push_cmd || rx_push;
  assign fifo_pop   = pop_req || hold_load;
  assign fifo_wdata = rx_push ? {1'b0, rx_data} : {push_cmd, hb_wdata};

  ppf_fifo #(.DEPTH(DEPTH), .W(EW), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(fifo_push),
    .wdata(fifo_wdata), .pop(fifo_pop), .head(fifo_head), .count(count),
    .empty(fifo_empty), .full(fifo_full)
  );

  ppf_svc #(.DEPTH(DEPTH), .THRESH(THRESH), .CW(CW)) u_svc (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .rev(rev), .count(count),
    .empty(fifo_empty), .full(fifo_full), .sie(sie), .dma_en(dma_en),
    .ack_n(ack_n_in), .irq_n(irq_n), .dma_req(dma_req), .svc_rise(svc_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_COMPAT;
      ecr_opt_q <= '0;
      ctrl_q    <= '0;
      cfgb_q    <= '0;
      pd_q      <= '0;
    end else begin
      if (wr_ecr) begin
        mode_q    <= mode_e'(hb_wdata[7:5]);
        ecr_opt_q <= hb_wdata[4:2];
      end
      if (wr_ctrl)  ctrl_q <= hb_wdata;
      if (wr_cfgb)  cfgb_q <= hb_wdata;
      if (wr_latch) pd_q   <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (hold_load) begin
      hold_v <= 1'b1;
      hold_q <= fifo_head;
    end else if (hold_take) begin
      hold_v <= 1'b0;
    end
  end

  assign tx_valid = hold_v;
  assign tx_data  = hold_q[7:0];
  assign tx_cmd   = hold_q[8];
  assign rx_ready = (mode_q == MD_ECP) && rev && !fifo_full;
  assign pd_out   = pd_q;

  always_comb begin
    case (rsel)
      RS_LATCH: hb_rdata = pd_q;
      RS_CTRL:  hb_rdata = ctrl_q;
      RS_FIFO:  hb_rdata = fifo_empty ? 8'h00 : fifo_head[7:0];
      RS_CFGA:  hb_rdata = CFGA_VAL;
      RS_CFGB:  hb_rdata = cfgb_q;
      RS_ECR:   hb_rdata = {mode_q, ecr_opt_q, fifo_full, fifo_empty};
      default:  hb_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/ppf_chk.sv
module ppf_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          rev,
  input logic          sie,
  input logic          dma_en,
  input logic          svc_evt,
  input logic          irq_n,
  input logic          dma_req,
  input logic          epp_addr_stb,
  input logic          epp_data_stb,
  input logic          flush,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data
);
  logic qmode;
  assign qmode = (mode == 3'd2) || (mode == 3'd3);

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  epp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_addr_stb || epp_data_stb) |-> (mode == 3'd4));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qmode && !irq_n) |=> (irq_n || !qmode));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_evt && sie && !dma_en) |=> (!irq_n || !qmode));

  // R10
  dma_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !rev && full) |=> !dma_req);

  // R10
  dma_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dma_en));

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !tx_valid));

  // R7
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data)));
endmodule

bind ppfifo_ctrl ppf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .count(count), .full(fifo_full),
  .empty(fifo_empty), .rev(rev), .sie(sie), .dma_en(dma_en), .svc_evt(svc_evt),
  .irq_n(irq_n), .dma_req(dma_req), .epp_addr_stb(epp_addr_stb),
  .epp_data_stb(epp_data_stb), .flush(flush), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/ppfifo_ctrl_tb.sv
module ppfifo_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hb_sel, hb_wr;
  logic [10:0] hb_addr;
  logic [7:0]  hb_wdata, hb_rdata, pd_out;
  logic        epp_addr_stb, epp_data_stb;
  logic        tx_valid, tx_cmd, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        ack_n_in, irq_n, dma_req;

  always #10 clk = ~clk;

  ppfifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .pd_out(pd_out),
    .epp_addr_stb(epp_addr_stb), .epp_data_stb(epp_data_stb),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_cmd(tx_cmd), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ack_n_in(ack_n_in), .irq_n(irq_n), .dma_req(dma_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  int low_cnt = 0;
  int cap_n = 0;
  logic cap_en = 1'b0;
  logic [8:0] cap_buf [32];
  logic done = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Observe irq pulses and holding-stage transfers mid-cycle.
  always begin
    @(negedge clk);
    #5;
    if (!irq_n) low_cnt++;
    if (cap_en && tx_valid && tx_ready && cap_n < 32) begin
      cap_buf[cap_n] = {tx_cmd, tx_data};
      cap_n++;
    end
  end

  task automatic bw(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0;
  endtask

  task automatic br(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = a;
    #2 d = hb_rdata;
    @(negedge clk);
    hb_sel = 1'b0;
  endtask

  task automatic probe(input logic [10:0] a, output logic ea, output logic ed);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = a;
    #2 ea = epp_addr_stb; ed = epp_data_stb;
    @(negedge clk);
    hb_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
  endtask

  // {write, offset, data, expected read}
  localparam logic [27:0] VEC [23] = '{
    {1'b1, 11'h402, 8'hC0, 8'h00},
    {1'b0, 11'h402, 8'h00, 8'hC1},
    {1'b1, 11'h400, 8'h11, 8'h00},
    {1'b1, 11'h400, 8'h22, 8'h00},
    {1'b1, 11'h400, 8'h33, 8'h00},
    {1'b0, 11'h402, 8'h00, 8'hC0},
    {1'b0, 11'h400, 8'h00, 8'h11},
    {1'b0, 11'h400, 8'h00, 8'h22},
    {1'b0, 11'h400, 8'h00, 8'h33},
    {1'b0, 11'h402, 8'h00, 8'hC1},
    {1'b0, 11'h400, 8'h00, 8'h00},
    {1'b1, 11'h402, 8'hE0, 8'h00},
    {1'b0, 11'h400, 8'h00, 8'h10},
    {1'b1, 11'h401, 8'h5A, 8'h00},
    {1'b0, 11'h401, 8'h00, 8'h5A},
    {1'b1, 11'h402, 8'h40, 8'h00},
    {1'b1, 11'h400, 8'h77, 8'h00},
    {1'b0, 11'h400, 8'h00, 8'h00},
    {1'b0, 11'h402, 8'h00, 8'h41},
    {1'b1, 11'h402, 8'h00, 8'h00},
    {1'b0, 11'h402, 8'h00, 8'h01},
    {1'b1, 11'h000, 8'hA5, 8'h00},
    {1'b0, 11'h000, 8'h00, 8'hA5}
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic ea, ed;
    rst_n = 1'b0; hb_sel = 1'b0; hb_wr = 1'b0; hb_addr = '0; hb_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; ack_n_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    br(11'h402, rd);
    chk("R1 ecr", rd, 8'h01);
    chk("R1 tx_valid", tx_valid, 1'b0);
    chk("R1 rx_ready", rx_ready, 1'b0);
    chk("R1 dma_req", dma_req, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);

    // R2/R5 register and test FIFO table
    for (int i = 0; i < 23; i++) begin
      if (VEC[i][27]) bw(VEC[i][26:16], VEC[i][15:8]);
      else begin
        br(VEC[i][26:16], rd);
        chk("R2/R5 table", rd, VEC[i][7:0]);
      end
    end
    chk("R3 latch pd_out", pd_out, 8'hA5);

    // R3 R5 R6 R7 R8 forward ECP fill: 1 command + 16 data + 1 dropped
    bw(11'h002, 8'h00);
    low_cnt = 0;
    bw(11'h402, 8'h64);
    bw(11'h000, 8'hC1);
    for (int k = 2; k <= 17; k++) bw(11'h400, 8'(k));
    bw(11'h400, 8'hEE);
    br(11'h402, rd);
    chk("R5 full flag", rd, 8'h66);
    chk("R3 cmd tag", {tx_valid, tx_cmd, tx_data}, {2'b11, 8'hC1});
    chk("R3 latch untouched", pd_out, 8'hA5);
    repeat (4) @(negedge clk);
    chk("R7 hold steady", {tx_valid, tx_data}, {1'b1, 8'hC1});
    chk("R8 one pulse on entry", low_cnt, 1);

    cap_n = 0; cap_en = 1'b1;
    @(negedge clk); tx_ready = 1'b1;
    repeat (25) @(negedge clk);
    tx_ready = 1'b0; cap_en = 1'b0;
    chk("R6 pending count", cap_n, 17);
    chk("R6 first byte", cap_buf[0], 9'h1C1);
    for (int k = 1; k < 17; k++) chk("R6 order", cap_buf[k], 9'(k + 1));
    chk("R8 pulse at threshold", low_cnt, 2);
    br(11'h402, rd);
    chk("R5 empty flag", rd, 8'h65);

    // R11 flush
    bw(11'h400, 8'hA1); bw(11'h400, 8'hA2); bw(11'h400, 8'hA3);
    chk("R11 hold loaded", tx_valid, 1'b1);
    bw(11'h402, 8'h20);
    br(11'h402, rd);
    chk("R11 flushed ecr", rd, 8'h21);
    chk("R11 hold cleared", tx_valid, 1'b0);
    bw(11'h402, 8'h64);
    repeat (3) @(negedge clk);
    chk("R11 nothing left", tx_valid, 1'b0);

    // R10 R12 reverse with DMA
    bw(11'h002, 8'h20);
    bw(11'h402, 8'h68);
    chk("R10 idle", dma_req, 1'b0);
    chk("R12 rx_ready", rx_ready, 1'b1);
    for (int k = 0; k < 7; k++) rx_push(8'(8'h30 + k));
    @(negedge clk); rx_valid = 1'b0;
    #5 chk("R10 below threshold", dma_req, 1'b0);
    rx_push(8'h37);
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    #5 chk("R10 threshold", dma_req, 1'b1);
    for (int k = 8; k < 16; k++) rx_push(8'(8'h30 + k));
    @(negedge clk); rx_valid = 1'b0;
    #5 chk("R12 full not ready", rx_ready, 1'b0);
    chk("R10 held at full reverse", dma_req, 1'b1);
    rx_push(8'hEE);
    @(negedge clk); rx_valid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      br(11'h400, rd);
      chk("R12 reverse order", rd, 8'(8'h30 + k));
      if (k == 14) chk("R10 hysteresis", dma_req, 1'b1);
    end
    br(11'h400, rd);
    chk("R5 dropped push", rd, 8'h00);
    chk("R10 drops on empty", dma_req, 1'b0);

    // R8 reverse pulse without DMA
    bw(11'h402, 8'h64);
    low_cnt = 0;
    for (int k = 0; k < 8; k++) rx_push(8'(k));
    @(negedge clk); rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reverse pulse", low_cnt, 1);
    bw(11'h402, 8'h00);
    br(11'h402, rd);
    chk("R11 reverse flush", rd, 8'h01);

    // R9 compatibility acknowledge level
    @(negedge clk); ack_n_in = 1'b0;
    #5 chk("R9 ack low", irq_n, 1'b0);
    repeat (3) @(negedge clk);
    #5 chk("R9 ack held", irq_n, 1'b0);
    @(negedge clk); ack_n_in = 1'b1;
    #5 chk("R9 ack high", irq_n, 1'b1);
    bw(11'h000, 8'h3C);
    chk("R3 data latch", pd_out, 8'h3C);

    // R4 EPP strobes
    probe(11'h003, ea, ed);
    chk("R4 off in mode 000", {ea, ed}, 2'b00);
    bw(11'h402, 8'h80);
    probe(11'h003, ea, ed);
    chk("R4 address port", {ea, ed}, 2'b10);
    probe(11'h006, ea, ed);
    chk("R4 data port", {ea, ed}, 2'b01);
    probe(11'h002, ea, ed);
    chk("R4 control offset", {ea, ed}, 2'b00);

    done = 1'b1;
    report();
    $finish;
  end
endmodule